// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from power-up to normal operation without any software help. Once reset is released it turns the SDRAM clock enable on and holds a quiet period of at least 200 microseconds. The length of that period is worked out from a clock-frequency parameter. It then drives the fixed bring-up order on the command pins: one precharge of all banks, eight auto-refresh commands, and one mode-register load. After that it raises `init_done` and starts a periodic refresh-request timer.

The geometry inputs arrive offset-encoded: columns minus 8, rows minus 11, banks minus 1. The block decodes them and, together with the bus-width flag, reports the device capacity in bytes. The precharge-to-refresh gap comes from the tRP field. The gap between refreshes, and between the last refresh and the mode load, comes from the tRC field. The mode word carries the CAS latency field and a burst-length code that is fixed by a parameter.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is held, `sd_cke`, `init_done` and `refresh_req` are 0 and the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111).
- R2: On the first clock edge after reset release, `sd_cke` goes to 1 and stays 1. No command other than NOP appears until PAUSE_CYC = ceil(CLK_HZ/1e6)*200 edges after that.
- R3: The precharge-all command (0010) appears exactly once, on edge 1+PAUSE_CYC, with address bit 10 high. The next command follows cfg_trp edges later, and a cfg_trp of 0 acts as 1.
- R4: Exactly eight auto-refresh commands (0001) are issued. Each is cfg_trc edges after the one before it, and a cfg_trc of 0 acts as 1.
- R5: The mode-register load (0000) follows the last refresh by cfg_trc edges. It drives `sd_ba` = 0, A[2:0] = BURST_CODE, A[3] = 0 (sequential), A[6:4] = cfg_cas, and all other address bits 0.
- R6: `init_done` rises two edges after the mode-register load and then stays high until reset.
- R7: After `init_done` rises, `refresh_req` pulses for one cycle every P edges. P is `refresh_period` (0 acts as 1), and the first pulse comes P edges after the rise.
- R8: A change to `refresh_period` while the timer runs takes effect only when the timer next reloads, which happens on the edge that produces a pulse.
- R9: `cap_bytes` = 2^(rows+cols+banks+1) when `cfg_bus16` is 1 and 2^(rows+cols+banks+2) when it is 0. Here cols = cfg_col_enc+8, rows = cfg_row_enc+11 and banks = cfg_bank_enc+1.
- R10: On every cycle not named in R3 to R5, including every cycle after `init_done`, the command pins carry NOP with `sd_ba` and `sd_addr` at 0.
- R11: `refresh_req` is never high while `init_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_col_enc | input | 2 | Column bits minus 8 |
| cfg_row_enc | input | 2 | Row bits minus 11 |
| cfg_bank_enc | input | 1 | Bank bits minus 1 |
| cfg_bus16 | input | 1 | 1 = 16-bit data bus, 0 = 32-bit |
| cfg_cas | input | 3 | CAS latency placed in the mode word |
| cfg_trp | input | 4 | Precharge period in cycles |
| cfg_trc | input | 4 | Row cycle time in cycles |
| refresh_period | input | 16 | Cycles between refresh requests |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Address pins |
| init_done | output | 1 | Bring-up complete |
| refresh_req | output | 1 | One-cycle refresh request pulse |
| cap_bytes | output | 32 | Device capacity in bytes |

## Verification
On every cycle the assertions check several properties. No command appears before the counted quiet period has passed, and the precharge always has A10 high. The mode load carries bank 0 and always follows exactly eight observed refreshes. `init_done` never falls, only NOP follows completion, and refresh requests never appear before completion.

Only the bench scenarios can show the exact edge on which each command lands for a given tRP and tRC, including the zero-as-one cases. The same holds for the pulse spacing of the refresh timer when a period is changed mid-run, and for the capacity value across the geometry range.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_RST,
        ST_PAUSE,
        ST_TRP,
        ST_TRC,
        ST_TMRD,
        ST_RUN
    } seq_st_e;

    localparam int NUM_INIT_REF = 8;
    localparam int MRD_CYC      = 2;
endpackage

// File: rtl/sdram_geom_dec.sv
module sdram_geom_dec #(
    parameter int CAP_W    = 32,
    parameter int COL_BASE = 8,
    parameter int ROW_BASE = 11,
    parameter int BANK_BASE = 1
) (
    input  logic [1:0]       col_enc,
    input  logic [1:0]       row_enc,
    input  logic             bank_enc,
    input  logic             bus16,
    output logic [CAP_W-1:0] cap
);
    localparam int EXP_W = $clog2(CAP_W);

    logic [EXP_W-1:0] exp_sum;

    always_comb begin
        exp_sum = EXP_W'(col_enc) + EXP_W'(COL_BASE)
                + EXP_W'(row_enc) + EXP_W'(ROW_BASE)
                + EXP_W'(bank_enc) + EXP_W'(BANK_BASE)
                + (bus16 ? EXP_W'(1) : EXP_W'(2));
        cap = CAP_W'(1) << exp_sum;
    end
endmodule

// File: rtl/sdram_refresh_tmr.sv
module sdram_refresh_tmr #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic             req
);
    typedef struct packed {
        logic [PER_W-1:0] tmr;
        logic             req;
    } tmr_s;

    tmr_s d, q;
    logic [PER_W-1:0] reload;

    always_comb begin
        reload = (period == '0) ? '0 : period - PER_W'(1);
        d      = q;
        d.req  = 1'b0;
        if (!run) begin
            d.tmr = reload;
        end else if (q.tmr == '0) begin
            d.req = 1'b1;
            d.tmr = reload;
        end else begin
            d.tmr = q.tmr - PER_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req = q.req;
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_seq_pkg::*;
#(
    parameter int         PAUSE_CYC  = 10000,
    parameter int         ADDR_W     = 13,
    parameter int         TW         = 4,
    parameter logic [2:0] BURST_CODE = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_cas,
    input  logic [TW-1:0]     cfg_trp,
    input  logic [TW-1:0]     cfg_trc,
    output logic              cke,
    output logic [3:0]        cmd,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam int PW    = $clog2(PAUSE_CYC + 1);
    localparam int CNT_W = (PW > TW + 1) ? PW : TW + 1;

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [3:0]        nref;
        logic              cke;
        logic [3:0]        cmd;
        logic [1:0]        ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } fsm_s;

    localparam fsm_s RST_Q = '{st: ST_RST, cnt: '0, nref: '0, cke: 1'b0,
                               cmd: CMD_NOP, ba: '0, addr: '0, done: 1'b0};

    fsm_s d, q;

    function automatic logic [CNT_W-1:0] gap_load(input logic [TW-1:0] t);
        return (t == '0) ? '0 : CNT_W'(t) - CNT_W'(1);
    endfunction

    always_comb begin
        d      = q;
        d.cmd  = CMD_NOP;
        d.ba   = '0;
        d.addr = '0;
        unique case (q.st)
            ST_RST: begin
                d.cke = 1'b1;
                d.cnt = CNT_W'(PAUSE_CYC - 1);
                d.st  = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (q.cnt == '0) begin
                    d.cmd      = CMD_PRE;
                    d.addr[10] = 1'b1;
                    d.cnt      = gap_load(cfg_trp);
                    d.st       = ST_TRP;
                end else d.cnt = q.cnt - CNT_W'(1);
            end
            ST_TRP: begin
                if (q.cnt == '0) begin
                    d.cmd  = CMD_REF;
                    d.nref = 4'd1;
                    d.cnt  = gap_load(cfg_trc);
                    d.st   = ST_TRC;
                end else d.cnt = q.cnt - CNT_W'(1);
            end
            ST_TRC: begin
                if (q.cnt == '0) begin
                    if (q.nref == 4'(NUM_INIT_REF)) begin
                        d.cmd       = CMD_MRS;
                        d.addr[2:0] = BURST_CODE;
                        d.addr[6:4] = cfg_cas;
                        d.cnt       = CNT_W'(MRD_CYC - 1);
                        d.st        = ST_TMRD;
                    end else begin
                        d.cmd  = CMD_REF;
                        d.nref = q.nref + 4'd1;
                        d.cnt  = gap_load(cfg_trc);
                    end
                end else d.cnt = q.cnt - CNT_W'(1);
            end
            ST_TMRD: begin
                if (q.cnt == '0) begin
                    d.done = 1'b1;
                    d.st   = ST_RUN;
                end else d.cnt = q.cnt - CNT_W'(1);
            end
            ST_RUN: begin
            end
            default: d.st = ST_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_Q;
        else        q <= d;
    end

    assign cke  = q.cke;
    assign cmd  = q.cmd;
    assign ba   = q.ba;
    assign addr = q.addr;
    assign done = q.done;

    // Checker state: cycles spent with the clock enable high, and refreshes seen.
    logic [CNT_W-1:0] chk_cke_cyc;
    logic [3:0]       chk_refs;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_cke_cyc <= '0;
            chk_refs    <= '0;
        end else begin
            if (cke && chk_cke_cyc != CNT_W'(PAUSE_CYC))
                chk_cke_cyc <= chk_cke_cyc + CNT_W'(1);
            if (cmd == CMD_REF && chk_refs != 4'hF)
                chk_refs <= chk_refs + 4'd1;
        end
    end

    // R2
    pause_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> (chk_cke_cyc >= CNT_W'(PAUSE_CYC)));
    // R3
    pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> addr[10]);
    // R4
    eight_refs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> (chk_refs == 4'(NUM_INIT_REF)));
    // R5
    mrs_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> (ba == 2'b00 && !addr[3]));
    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    // R10
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd == CMD_NOP && addr == '0));
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_seq_pkg::*;
#(
    parameter int         CLK_HZ     = 50_000_000,
    parameter int         PAUSE_US   = 200,
    parameter int         ADDR_W     = 13,
    parameter int         PER_W      = 16,
    parameter int         CAP_W      = 32,
    parameter logic [2:0] BURST_CODE = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_col_enc,
    input  logic [1:0]        cfg_row_enc,
    input  logic              cfg_bank_enc,
    input  logic              cfg_bus16,
    input  logic [2:0]        cfg_cas,
    input  logic [3:0]        cfg_trp,
    input  logic [3:0]        cfg_trc,
    input  logic [PER_W-1:0]  refresh_period,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [1:0]        sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done,
    output logic              refresh_req,
    output logic [CAP_W-1:0]  cap_bytes
);
    localparam int CYC_PER_US = (CLK_HZ + 999_999) / 1_000_000;
    localparam int PAUSE_CYC  = CYC_PER_US * PAUSE_US;

    logic [3:0] cmd;

    sdram_init_fsm #(
        .PAUSE_CYC (PAUSE_CYC),
        .ADDR_W    (ADDR_W),
        .TW        (4),
        .BURST_CODE(BURST_CODE)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_cas(cfg_cas),
        .cfg_trp(cfg_trp),
        .cfg_trc(cfg_trc),
        .cke    (sd_cke),
        .cmd    (cmd),
        .ba     (sd_ba),
        .addr   (sd_addr),
        .done   (init_done)
    );

    sdram_refresh_tmr #(.PER_W(PER_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (init_done),
        .period(refresh_period),
        .req   (refresh_req)
    );

    sdram_geom_dec #(.CAP_W(CAP_W)) u_geom (
        .col_enc (cfg_col_enc),
        .row_enc (cfg_row_enc),
        .bank_enc(cfg_bank_enc),
        .bus16   (cfg_bus16),
        .cap     (cap_bytes)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    // R11
    req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> init_done);
endmodule

// File: tb/tb_sdram_pwrup_seq.sv
module tb_sdram_pwrup_seq;
    localparam int         PAUSE_EXP = 10000;  // 200 us at 20 ns per cycle
    localparam logic [2:0] BURST     = 3'b011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_col_enc = '0, cfg_row_enc = '0;
    logic        cfg_bank_enc = 1'b0, cfg_bus16 = 1'b0;
    logic [2:0]  cfg_cas = 3'd2;
    logic [3:0]  cfg_trp = 4'd2, cfg_trc = 4'd4;
    logic [15:0] refresh_period = 16'd8;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic        init_done, refresh_req;
    logic [31:0] cap_bytes;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    sdram_pwrup_seq #(.CLK_HZ(50_000_000), .BURST_CODE(BURST)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_col_enc(cfg_col_enc), .cfg_row_enc(cfg_row_enc),
        .cfg_bank_enc(cfg_bank_enc), .cfg_bus16(cfg_bus16),
        .cfg_cas(cfg_cas), .cfg_trp(cfg_trp), .cfg_trc(cfg_trc),
        .refresh_period(refresh_period),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .init_done(init_done),
        .refresh_req(refresh_req), .cap_bytes(cap_bytes)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [3:0] exp_cmd(input int k, input int trp_e, input int trc_e);
        int e0 = 1 + PAUSE_EXP;
        if (k == e0) return 4'b0010;
        for (int i = 0; i < 8; i++)
            if (k == e0 + trp_e + i * trc_e) return 4'b0001;
        if (k == e0 + trp_e + 8 * trc_e) return 4'b0000;
        return 4'b0111;
    endfunction

    function automatic string cmd_tag(input logic [3:0] c, input int k);
        if (c == 4'b0010) return "R3";
        if (c == 4'b0001) return "R4";
        if (c == 4'b0000) return "R5";
        if (k <= PAUSE_EXP) return "R2";
        return "R10";
    endfunction

    task automatic run_init(input int trp, input int trc, input int cas,
                            input int per0, input int tail,
                            input bit chg, input int per_new);
        int trp_e = eff(trp);
        int trc_e = eff(trc);
        int em, dn, nxt, per_at;
        logic [3:0]  got, ec;
        logic [12:0] mode;
        bit er;
        rst_n = 1'b0;
        cfg_trp = 4'(trp);
        cfg_trc = 4'(trc);
        cfg_cas = 3'(cas);
        refresh_period = 16'(per0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(sd_cke == 1'b0, "R1", "cke in reset", sd_cke, 0);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "cmd in reset",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        check(init_done == 1'b0, "R1", "done in reset", init_done, 0);
        check(refresh_req == 1'b0, "R1", "req in reset", refresh_req, 0);
        rst_n = 1'b1;
        em = 1 + PAUSE_EXP + trp_e + 8 * trc_e;
        dn = em + 2;
        nxt = -1;
        per_at = per0;
        mode = {6'b0, 3'(cas), 1'b0, BURST};
        for (int k = 1; k <= dn + tail; k++) begin
            @(posedge clk);
            @(negedge clk);
            got = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            ec  = exp_cmd(k, trp_e, trc_e);
            check(got == ec, cmd_tag(ec, k), "command", got, ec);
            check(sd_cke == 1'b1, "R2", "cke high", sd_cke, 1);
            if (ec == 4'b0010)
                check(sd_addr[10] == 1'b1, "R3", "precharge A10", sd_addr[10], 1);
            else if (ec == 4'b0000) begin
                check(sd_ba == 2'b00, "R5", "mode bank", sd_ba, 0);
                check(sd_addr == mode, "R5", "mode word", sd_addr, mode);
            end else
                check(sd_addr == '0 && sd_ba == '0, "R10", "idle address",
                      {sd_ba, sd_addr}, 0);
            check(init_done == (k >= dn), "R6", "init_done", init_done, k >= dn);
            er = 1'b0;
            if (k == dn) nxt = dn + eff(per_at);
            else if (k == nxt) begin
                er = 1'b1;
                nxt = k + eff(per_at);
            end
            if (k < dn)
                check(refresh_req == 1'b0, "R11", "req before done", refresh_req, 0);
            else if (chg && k > dn + 3)
                check(refresh_req == er, "R8", "req after period change", refresh_req, er);
            else
                check(refresh_req == er, "R7", "refresh pulse", refresh_req, er);
            if (chg && k == dn + 3) refresh_period = 16'(per_new);
            per_at = refresh_period;
        end
    endtask

    task automatic check_cap(input int c, input int r, input int b, input bit w16);
        longint exp_v;
        cfg_col_enc = 2'(c);
        cfg_row_enc = 2'(r);
        cfg_bank_enc = b[0];
        cfg_bus16 = w16;
        #1;
        exp_v = longint'(1) << ((r + 11) + (c + 8) + (b + 1) + (w16 ? 1 : 2));
        // R9
        check(longint'(cap_bytes) == exp_v, "R9", "capacity", cap_bytes, exp_v);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        @(negedge clk);
        check_cap(0, 0, 0, 1'b1);
        check_cap(3, 3, 1, 1'b0);
        check_cap(1, 2, 0, 1'b0);
        for (int i = 0; i < 20; i++)
            check_cap(int'($urandom % 4), int'($urandom % 4), int'($urandom % 2),
                      1'($urandom % 2));
        // zero timings act as one, period 1 pulses every cycle
        run_init(0, 0, 2, 1, 6, 1'b0, 0);
        // longest timings
        run_init(15, 15, 3, 4, 20, 1'b0, 0);
        // period changed while running
        run_init(3, 7, 2, 5, 30, 1'b1, 3);
        // zero period lengthened mid-run
        run_init(1, 2, 3, 0, 20, 1'b1, 6);
        for (int i = 0; i < 2; i++)
            run_init(int'($urandom % 15) + 1, int'($urandom % 15) + 1,
                     int'($urandom % 8), int'($urandom % 20) + 1, 50, 1'b1,
                     int'($urandom % 20) + 1);
        finish_run();
    end
endmodule